// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block decides, once per clock, whether a conditional relative jump is taken. It also produces the instruction pointer that fetch should use next. The inputs are:

- the five status flags: carry, zero, sign, overflow and parity;
- a 4-bit condition code;
- the address of the instruction that follows the jump;
- a signed 8-bit displacement.

The decision uses only the flag values presented in the same cycle. Signed relations (less, greater) are judged from sign, overflow and zero. Unsigned relations (below, above) are judged from carry and zero. The overflow flag plays no part in any unsigned test.

The condition code is read as a 3-bit base test in bits 3..1 and an invert bit in bit 0. This gives eight tests and their eight complements. The base tests, by code value, are:

| Base (bits 3..1) | Test | Taken when |
|---|---|---|
| 0 | overflow | O = 1 |
| 1 | below | C = 1 |
| 2 | equal | Z = 1 |
| 3 | below-or-equal | C or Z |
| 4 | sign | S = 1 |
| 5 | parity | P = 1 |
| 6 | less | S xor O |
| 7 | less-or-equal | (S xor O) or Z |

When the jump is taken, the target is the next-instruction address plus the sign-extended displacement, wrapped to the address width. This gives a reach of -128 to +127 bytes. When the jump is not taken, the next-instruction address passes through unchanged. Both outputs are registered, so they follow the inputs by one clock.

Top module: `bru_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, taken becomes 0 and target_ip becomes 0 after that edge.
- R2: Out of reset, taken and target_ip reflect the inputs sampled at the previous rising edge, with exactly one cycle of latency.
- R3: For every base test, the code with bit 0 = 1 is taken exactly when the same base with bit 0 = 0 is not taken, under the same flags.
- R4: Code 4 (equal) is taken when Z = 1, and code 5 (not equal) is taken when Z = 0. No other flag affects them.
- R5: Code 2 (below) is taken when C = 1, and code 3 when C = 0. Code 6 (below-or-equal) is taken when C or Z is 1, and code 7 (above) when both are 0. The overflow flag never affects codes 2, 3, 6 or 7.
- R6: Code 12 (less) is taken when S xor O is 1, and code 13 (greater-or-equal) when it is 0. Code 14 (less-or-equal) is taken when (S xor O) or Z is 1, and code 15 (greater) when it is 0.
- R7: Code 0 is taken when O = 1, code 8 when S = 1 and code 10 when P = 1. Codes 1, 9 and 11 are their complements.
- R8: When taken, target_ip equals next_ip plus the sign-extended displacement, modulo 2^16.
- R9: When not taken, target_ip equals next_ip unchanged, whatever the displacement.
- R10: The target wraps across the address boundary in both directions, for example 0xFFF0 + 0x7F gives 0x006F and 0x0010 + 0x80 gives 0xFF90.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_c | input | 1 | Carry/borrow flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_o | input | 1 | Signed overflow flag |
| flag_p | input | 1 | Parity flag |
| cond_code | input | 4 | Base test in bits 3..1, invert in bit 0 |
| next_ip | input | 16 | Address of the instruction after the jump |
| disp | input | 8 | Signed relative displacement |
| taken | output | 1 | Registered jump decision |
| target_ip | output | 16 | Registered next instruction pointer |

## Verification
The bench builds the unit with its default widths: a 16-bit address and an 8-bit displacement. At these widths every code can be crossed with all 32 flag combinations, and both ends of the displacement range (0x7F and 0x80) can be driven against addresses next to 0x0000 and 0xFFFF. This reaches the carry out of the low byte and the borrow into the high byte of the split adder. Randomised cycles then feed a behavioural model, whose per-code formulas are written independently of the base-plus-invert decode.

// File: rtl/bru_pkg.sv
// Package: shared types for the conditional relative branch unit.
// Assumes a 4-bit condition code split as {base[2:0], invert}.
package bru_pkg;

    // Status flags as one bundle.
    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic o;
        logic p;
    } bru_flags_t;

    // Base tests selected by condition code bits 3..1.
    typedef enum logic [2:0] {
        BT_OVF      = 3'd0,
        BT_BELOW    = 3'd1,
        BT_EQUAL    = 3'd2,
        BT_BELOW_EQ = 3'd3,
        BT_SIGN     = 3'd4,
        BT_PARITY   = 3'd5,
        BT_LESS     = 3'd6,
        BT_LESS_EQ  = 3'd7
    } bru_base_t;

endpackage

// File: rtl/bru_cond_eval.sv
// Module: bru_cond_eval
// Combinational decision: selects a base test from cc[3:1] and inverts
// it when cc[0] is set. Assumes the flags are stable for the whole cycle;
// no state is kept here.
module bru_cond_eval
    import bru_pkg::*;
#(
    parameter int CC_W = 4
) (
    input  bru_flags_t      flags,
    input  logic [CC_W-1:0] cc,
    output logic            hit
);

    bru_base_t base_sel;
    logic      base_hit;
    logic      lt_signed;

    // Signed less-than term shared by two base tests.
    always_comb lt_signed = flags.s ^ flags.o;

    // Map the code to its base test.
    always_comb base_sel = bru_base_t'(cc[CC_W-1:1]);

    // Evaluate the selected base test.
    always_comb begin
        unique case (base_sel)
            BT_OVF:      base_hit = flags.o;
            BT_BELOW:    base_hit = flags.c;
            BT_EQUAL:    base_hit = flags.z;
            BT_BELOW_EQ: base_hit = flags.c | flags.z;
            BT_SIGN:     base_hit = flags.s;
            BT_PARITY:   base_hit = flags.p;
            BT_LESS:     base_hit = lt_signed;
            BT_LESS_EQ:  base_hit = lt_signed | flags.z;
            default:     base_hit = 1'b0;
        endcase
    end

    // Apply the invert bit.
    always_comb hit = base_hit ^ cc[0];

endmodule

// File: rtl/bru_target_add.sv
// Module: bru_target_add
// Computes next_ip + sign_extend(disp) modulo 2^ADDR_W. With SPLIT_ADD=1
// only the low DISP_W bits use a full adder; the upper part is
// incremented, decremented or passed through. Assumes ADDR_W > DISP_W.
module bru_target_add #(
    parameter int ADDR_W    = 16,
    parameter int DISP_W    = 8,
    parameter bit SPLIT_ADD = 1'b1
) (
    input  logic [ADDR_W-1:0] base_ip,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] sum_ip
);

    localparam int HI_W = ADDR_W - DISP_W;

    generate
        if (SPLIT_ADD) begin : g_split
            logic [DISP_W:0]   lo_sum;
            logic [HI_W-1:0]   hi_in;
            logic [HI_W-1:0]   hi_out;
            logic              lo_carry;
            logic              neg;

            // Add the displacement into the low field.
            always_comb lo_sum = {1'b0, base_ip[DISP_W-1:0]} + {1'b0, disp};

            // Split out the carry, the sign and the upper field.
            always_comb begin
                lo_carry = lo_sum[DISP_W];
                neg      = disp[DISP_W-1];
                hi_in    = base_ip[ADDR_W-1:DISP_W];
            end

            // Adjust the upper field by +1, -1 or 0.
            always_comb begin
                if (!neg && lo_carry)
                    hi_out = hi_in + HI_W'(1);
                else if (neg && !lo_carry)
                    hi_out = hi_in - HI_W'(1);
                else
                    hi_out = hi_in;
            end

            // Join the two fields.
            always_comb sum_ip = {hi_out, lo_sum[DISP_W-1:0]};
        end else begin : g_full
            logic [ADDR_W-1:0] ext;

            // Sign-extend, then use one full-width adder.
            always_comb ext = {{HI_W{disp[DISP_W-1]}}, disp};

            // Full-width sum.
            always_comb sum_ip = base_ip + ext;
        end
    endgenerate

endmodule

// File: rtl/bru_top.sv
// Module: bru_top
// Conditional relative branch unit. Samples flags, code, next address
// and displacement each clock. One cycle later it presents the decision
// and the pointer to fetch from. Reset is synchronous and active-low.
module bru_top
    import bru_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DISP_W    = 8,
    parameter int CC_W      = 4,
    parameter bit SPLIT_ADD = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_c,
    input  logic              flag_z,
    input  logic              flag_s,
    input  logic              flag_o,
    input  logic              flag_p,
    input  logic [CC_W-1:0]   cond_code,
    input  logic [ADDR_W-1:0] next_ip,
    input  logic [DISP_W-1:0] disp,
    output logic              taken,
    output logic [ADDR_W-1:0] target_ip
);

    localparam int HI_W = ADDR_W - DISP_W;

    bru_flags_t        flags;
    logic              hit;
    logic [ADDR_W-1:0] jump_ip;
    logic              primed;

    // Bundle the flag pins.
    always_comb flags = '{c: flag_c, z: flag_z, s: flag_s, o: flag_o, p: flag_p};

    bru_cond_eval #(.CC_W(CC_W)) u_cond (
        .flags (flags),
        .cc    (cond_code),
        .hit   (hit)
    );

    bru_target_add #(
        .ADDR_W    (ADDR_W),
        .DISP_W    (DISP_W),
        .SPLIT_ADD (SPLIT_ADD)
    ) u_add (
        .base_ip (next_ip),
        .disp    (disp),
        .sum_ip  (jump_ip)
    );

    // Register the decision and the selected pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken     <= 1'b0;
            target_ip <= '0;
        end else begin
            taken     <= hit;
            target_ip <= hit ? jump_ip : next_ip;
        end
    end

    // Marks that the previous edge was out of reset; used by the checks.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R9: a jump that is not taken passes the address through.
    a_r9_not_taken_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !taken) |-> (target_ip == $past(next_ip)));

    // R8: a taken jump lands at the address plus the sign-extended displacement.
    a_r8_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && taken) |->
        (target_ip == ADDR_W'($past(next_ip) + {{HI_W{$past(disp[DISP_W-1])}}, $past(disp)})));

    // R4: equal follows the zero flag.
    a_r4_equal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(cond_code) == CC_W'(4)) |-> (taken == $past(flag_z)));

    // R5: below follows carry.
    a_r5_below_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(cond_code) == CC_W'(2)) |-> (taken == $past(flag_c)));

    // R6: greater-or-equal is taken when sign equals overflow.
    a_r6_ge_signed: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(cond_code) == CC_W'(13)) |-> (taken == ($past(flag_s) == $past(flag_o))));

    // R2: outputs hold when the inputs held.
    a_r2_stable_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $stable(next_ip) && $stable(disp) && $stable(cond_code) && $stable(flags))
        |=> ($stable(taken) && $stable(target_ip)));

endmodule

// File: tb/tb_bru_top.sv
`timescale 1ns/1ps
// Bench for bru_top: behavioural reference model compared on every clock.
module tb_bru_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flag_c = 0, flag_z = 0, flag_s = 0, flag_o = 0, flag_p = 0;
    logic [3:0]  cond_code = '0;
    logic [15:0] next_ip = '0;
    logic [7:0]  disp = '0;
    logic        taken;
    logic [15:0] target_ip;

    int errors = 0;
    int checks = 0;

    bit          pend = 0;
    bit          pend_reset = 0;
    bit          exp_taken;
    int          exp_ip;
    int          exp_cc;
    bit          exp_wrap;

    always #2 clk = ~clk;

    bru_top dut (
        .clk(clk), .rst_n(rst_n),
        .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o), .flag_p(flag_p),
        .cond_code(cond_code), .next_ip(next_ip), .disp(disp),
        .taken(taken), .target_ip(target_ip)
    );

    // Reference decision with one formula per code.
    function automatic bit ref_taken(int cc, bit c, bit z, bit s, bit o, bit p);
        case (cc)
            0:  return o;
            1:  return !o;
            2:  return c;
            3:  return !c;
            4:  return z;
            5:  return !z;
            6:  return c || z;
            7:  return !c && !z;
            8:  return s;
            9:  return !s;
            10: return p;
            11: return !p;
            12: return s != o;
            13: return s == o;
            14: return (s != o) || z;
            default: return (s == o) && !z;
        endcase
    endfunction

    function automatic string req_of(int cc);
        case (cc)
            4, 5:            return "R4";
            2, 3, 6, 7:      return "R5";
            12, 13, 14, 15:  return "R6";
            default:         return "R7";
        endcase
    endfunction

    // Compare the outputs with the pending expectation.
    task automatic check_pending();
        if (!pend) return;
        checks++;
        if (pend_reset) begin
            if (taken !== 1'b0 || target_ip !== 16'h0000) begin
                errors++;
                $display("FAIL R1 reset: taken=%0b ip=%h expected taken=0 ip=0000", taken, target_ip);
            end
        end else if (taken !== exp_taken || target_ip !== exp_ip[15:0]) begin
            errors++;
            $display("FAIL R2 %s %s %s cc=%0d: taken=%0b ip=%h expected taken=%0b ip=%h",
                     req_of(exp_cc), (exp_cc % 2) ? "R3" : "-",
                     exp_taken ? (exp_wrap ? "R10" : "R8") : "R9",
                     exp_cc, taken, target_ip, exp_taken, exp_ip[15:0]);
        end
    endtask

    // At a falling edge: check, drive new inputs, set the expectation.
    task automatic step(bit rs, int cc, bit c, bit z, bit s, bit o, bit p, int nip, int d);
        int sd;
        int sum;
        @(negedge clk);
        check_pending();
        rst_n = rs; cond_code = cc[3:0];
        flag_c = c; flag_z = z; flag_s = s; flag_o = o; flag_p = p;
        next_ip = nip[15:0]; disp = d[7:0];
        sd = (d[7:0] >= 128) ? int'(d[7:0]) - 256 : int'(d[7:0]);
        sum = int'(nip[15:0]) + sd;
        pend = 1; pend_reset = !rs; exp_cc = cc;
        exp_taken = ref_taken(cc, c, z, s, o, p);
        exp_wrap = (sum < 0) || (sum > 65535);
        exp_ip = exp_taken ? (sum & 32'hFFFF) : int'(nip[15:0]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset with busy inputs.
        step(0, 4, 1, 1, 1, 1, 1, 16'h1234, 8'h10);
        step(0, 5, 0, 0, 0, 0, 0, 16'hABCD, 8'h80);
        // Exhaustive codes x flags (R3..R9).
        for (int cc = 0; cc < 16; cc++)
            for (int f = 0; f < 32; f++)
                step(1, cc, f[0], f[1], f[2], f[3], f[4], 16'h4000 + cc * 37 + f, (f * 11 + cc) & 255);
        // R10: boundary wraps, forced taken via code 4 with Z=1.
        step(1, 4, 0, 1, 0, 0, 0, 16'hFFF0, 8'h7F);
        step(1, 4, 0, 1, 0, 0, 0, 16'h0010, 8'h80);
        step(1, 4, 0, 1, 0, 0, 0, 16'hFF81, 8'h7F);
        step(1, 4, 0, 1, 0, 0, 0, 16'h0000, 8'hFF);
        step(1, 4, 0, 1, 0, 0, 0, 16'hFFFF, 8'h01);
        step(1, 4, 0, 1, 0, 0, 0, 16'h0100, 8'h80);
        // R9: not taken with extreme displacements.
        step(1, 5, 0, 1, 0, 0, 0, 16'hFFF0, 8'h7F);
        step(1, 5, 0, 1, 0, 0, 0, 16'h0010, 8'h80);
        // R1 again mid-run, then recovery.
        step(0, 4, 0, 1, 0, 0, 0, 16'h5555, 8'h22);
        step(1, 4, 0, 1, 0, 0, 0, 16'h5555, 8'h22);
        // Random cycles, with repeats to hold inputs stable.
        for (int i = 0; i < 400; i++) begin
            int r = $urandom;
            step(1, r & 15, r[4], r[5], r[6], r[7], r[8], $urandom & 16'hFFFF, $urandom & 255);
            if (r[9]) step(1, r & 15, r[4], r[5], r[6], r[7], r[8], int'(next_ip), int'(disp));
        end
        @(negedge clk);
        check_pending();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule